// File: doc/BRIEF.md
# DMA Command Port and Channel Register Front End

This block is the software-facing front end of an eight-channel DMA controller split into two groups of four channels. It decodes single-cycle I/O strobes against the full I/O address. It holds the 16-bit base address and word count registers of every channel and hands them to the transfer engine through flat output vectors. Software reaches each 16-bit register through an 8-bit data port, so it is accessed one byte at a time. A per-group byte-pointer flip-flop decides which half the next access touches.

Each group also owns three data-less command ports. The first rewinds its byte pointer. The second performs a master clear: it returns the group to its reset condition, masks every channel and drives a one-cycle clear pulse to the command, status and request registers held elsewhere. The third unmasks all four channels at once. The two groups are fully independent. The block also shows, per group, whether the group sits in its idle state. The transfer engine leaves idle through a start input, and master clear or reset returns the group to idle.

Top module: `dma_cmd_front`

## Requirements
- R1: After hardware reset, mask_o reads 8'hFF, bptr_o reads 2'b00, idle_o reads 2'b11, clr_regs_o reads 2'b00 and every address and count register holds zero.
- R2: The address register of group 0 channel n sits at I/O address 2n and its count register at 2n+1. For group 1, channel n (4+n overall) has its address at 0x0C0+4n and its count at 0x0C2+4n. All 16 address bits are decoded. Channel k occupies bits [16k+15:16k] of ch_addr_o and ch_count_o.
- R3: When the group's byte pointer is 0, an access reaches bits [7:0] of the register; when it is 1, bits [15:8]. Every read or write of any address or count register of a group toggles that group's pointer. A read returns the selected byte on io_rdata with io_rd_hit high in the same cycle as the strobe.
- R4: A write of any data to 0x00C clears the group 0 byte pointer, and a write to 0x0D8 clears the group 1 pointer. The clear takes effect on the edge that samples the strobe.
- R5: A write of any data to 0x00D (group 0) or 0x0DA (group 1) does the following to that group: its byte pointer is cleared, its four mask bits are set, it becomes idle, and its clr_regs_o bit is high for the one cycle after the edge.
- R6: A write of any data to 0x00E clears mask_o[3:0], and a write to 0x0DC clears mask_o[7:4].
- R7: No command to one group changes the other group's byte pointer, mask bits, idle flag, clear pulse or registers.
- R8: A read of a command port never raises io_rd_hit and leaves the byte pointer unchanged. The data written to a command port has no effect.
- R9: A high eng_start[g] clears idle_o[g]. Master clear of the same group in the same cycle wins and leaves the group idle.
- R10: A strobe to an unmapped address has no effect. This covers an offset inside a group's window that is not a register or command, an odd address in the group 1 window, and an address with any bit above the window set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| eng_start | input | 2 | Per group: transfer engine leaves idle |
| io_rdata | output | 8 | Read data byte |
| io_rd_hit | output | 1 | High when this block answers the read |
| mask_o | output | 8 | Per-channel mask bits, bit k is channel k |
| bptr_o | output | 2 | Per-group byte-pointer flip-flop |
| idle_o | output | 2 | Per-group idle flag |
| clr_regs_o | output | 2 | Per-group clear pulse for command, status and request registers |
| ch_addr_o | output | 128 | Address registers, 16 bits per channel |
| ch_count_o | output | 128 | Count registers, 16 bits per channel |

## Verification
The bench builds the block with its default parameters: two groups of four channels, 16-bit addresses, group 0 at base 0x000 with byte spacing and group 1 at 0x0C0 with word spacing. With these values both decode variants are exercised. These include the aligned and misaligned paths of the word-spaced group, the out-of-window offsets 8 to 11 and upper-address aliases. The interleaved pointer rewinds and cross-group commands reach the exact port numbers that software uses.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ADDR,
        ACC_CNT,
        ACC_CLR_BP,
        ACC_MCLR,
        ACC_CLR_MASK
    } acc_kind_e;

    // command offsets inside a group's window, after spacing is removed
    localparam int OFF_CLR_BP   = 12;
    localparam int OFF_MCLR     = 13;
    localparam int OFF_CLR_MASK = 14;
    localparam int WIN_SLOTS    = 16;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CH     = 4,
    parameter int BASE   = 0,
    parameter int SHIFT  = 0,
    localparam int CW    = (CH > 1) ? $clog2(CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [CW-1:0]     chan
);

    localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << SHIFT) - 1);
    localparam logic [ADDR_W-1:0] REG_LIM  = ADDR_W'(2 * CH);

    logic [ADDR_W-1:0] diff;
    logic [ADDR_W-1:0] loc;
    logic              in_win;

    always_comb begin
        diff   = addr - BASE_V;
        loc    = diff >> SHIFT;
        in_win = (addr >= BASE_V) && ((diff & LOW_MASK) == '0);
        kind   = ACC_NONE;
        chan   = loc[CW:1];
        if (in_win) begin
            if (loc < REG_LIM) begin
                kind = loc[0] ? ACC_CNT : ACC_ADDR;
            end else if (loc == ADDR_W'(OFF_CLR_BP)) begin
                kind = ACC_CLR_BP;
            end else if (loc == ADDR_W'(OFF_MCLR)) begin
                kind = ACC_MCLR;
            end else if (loc == ADDR_W'(OFF_CLR_MASK)) begin
                kind = ACC_CLR_MASK;
            end
        end
    end

endmodule

// File: rtl/dma_group_ctl.sv
module dma_group_ctl
    import dma_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CH     = 4,
    parameter int BASE   = 0,
    parameter int SHIFT  = 0,
    localparam int REG_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [DATA_W-1:0]   io_wdata,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic                eng_start,
    output logic                rd_hit,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CH-1:0]       mask,
    output logic                bptr,
    output logic                idle,
    output logic                clr_regs,
    output logic [CH*REG_W-1:0] addr_flat,
    output logic [CH*REG_W-1:0] cnt_flat
);

    localparam int CW = (CH > 1) ? $clog2(CH) : 1;

    typedef struct packed {
        logic                       bptr;
        logic [CH-1:0]              mask;
        logic                       idle;
        logic                       clr;
        logic [CH-1:0][REG_W-1:0]   addr;
        logic [CH-1:0][REG_W-1:0]   cnt;
    } grp_st_t;

    grp_st_t   st_d, st_q;
    acc_kind_e kind;
    logic [CW-1:0] chan;
    logic      wr_act, rd_act, is_reg;
    logic [REG_W-1:0] rd_word;

    dma_port_decode #(
        .ADDR_W (ADDR_W),
        .CH     (CH),
        .BASE   (BASE),
        .SHIFT  (SHIFT)
    ) u_dec (
        .addr (io_addr),
        .kind (kind),
        .chan (chan)
    );

    assign wr_act = io_wr;
    assign rd_act = io_rd && !io_wr;
    assign is_reg = (kind == ACC_ADDR) || (kind == ACC_CNT);

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (eng_start) begin
            st_d.idle = 1'b0;
        end
        case (kind)
            ACC_ADDR, ACC_CNT: begin
                if (wr_act) begin
                    if (kind == ACC_ADDR) begin
                        if (st_q.bptr) st_d.addr[chan][REG_W-1:DATA_W] = io_wdata;
                        else           st_d.addr[chan][DATA_W-1:0]     = io_wdata;
                    end else begin
                        if (st_q.bptr) st_d.cnt[chan][REG_W-1:DATA_W]  = io_wdata;
                        else           st_d.cnt[chan][DATA_W-1:0]      = io_wdata;
                    end
                end
                if (wr_act || rd_act) begin
                    st_d.bptr = !st_q.bptr;
                end
            end
            ACC_CLR_BP: begin
                if (wr_act) st_d.bptr = 1'b0;
            end
            ACC_MCLR: begin
                if (wr_act) begin
                    st_d.bptr = 1'b0;
                    st_d.mask = '1;
                    st_d.idle = 1'b1;
                    st_d.clr  = 1'b1;
                end
            end
            ACC_CLR_MASK: begin
                if (wr_act) st_d.mask = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = (kind == ACC_CNT) ? st_q.cnt[chan] : st_q.addr[chan];
        rd_hit  = rd_act && is_reg;
        rd_data = '0;
        if (rd_hit) begin
            rd_data = st_q.bptr ? rd_word[REG_W-1:DATA_W] : rd_word[DATA_W-1:0];
        end
    end

    assign mask      = st_q.mask;
    assign bptr      = st_q.bptr;
    assign idle      = st_q.idle;
    assign clr_regs  = st_q.clr;
    assign addr_flat = st_q.addr;
    assign cnt_flat  = st_q.cnt;

    assert_bptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_act || rd_act) && is_reg) |=> (bptr != $past(bptr)));

    assert_clr_bptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && kind == ACC_CLR_BP) |=> !bptr);

    assert_mclr_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && kind == ACC_MCLR) |=> (!bptr && (&mask) && idle && clr_regs));

    assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act && kind == ACC_MCLR) |=> !clr_regs);

    assert_clr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && kind == ACC_CLR_MASK) |=> (mask == '0));

    assert_cmd_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !is_reg) |-> !rd_hit);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_NONE) |=> ($stable(bptr) && $stable(mask) && $stable(addr_flat) && $stable(cnt_flat)));

    assert_idle_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !(wr_act && kind == ACC_MCLR)) |=> !idle);

endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
    import dma_cmd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CH      = 4,
    parameter int NUM_GRP = 2,
    parameter logic [NUM_GRP*ADDR_W-1:0] GRP_BASE  = {16'h00C0, 16'h0000},
    parameter logic [NUM_GRP-1:0]        GRP_SHIFT = 2'b10,
    localparam int REG_W  = 2 * DATA_W,
    localparam int NUM_CH = NUM_GRP * CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic [DATA_W-1:0]       io_wdata,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [NUM_GRP-1:0]      eng_start,
    output logic [DATA_W-1:0]       io_rdata,
    output logic                    io_rd_hit,
    output logic [NUM_CH-1:0]       mask_o,
    output logic [NUM_GRP-1:0]      bptr_o,
    output logic [NUM_GRP-1:0]      idle_o,
    output logic [NUM_GRP-1:0]      clr_regs_o,
    output logic [NUM_CH*REG_W-1:0] ch_addr_o,
    output logic [NUM_CH*REG_W-1:0] ch_count_o
);

    logic [NUM_GRP-1:0]             grp_hit;
    logic [NUM_GRP-1:0][DATA_W-1:0] grp_data;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        dma_group_ctl #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .CH     (CH),
            .BASE   (int'(GRP_BASE[g*ADDR_W +: ADDR_W])),
            .SHIFT  (int'(GRP_SHIFT[g]))
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .io_addr   (io_addr),
            .io_wdata  (io_wdata),
            .io_wr     (io_wr),
            .io_rd     (io_rd),
            .eng_start (eng_start[g]),
            .rd_hit    (grp_hit[g]),
            .rd_data   (grp_data[g]),
            .mask      (mask_o[g*CH +: CH]),
            .bptr      (bptr_o[g]),
            .idle      (idle_o[g]),
            .clr_regs  (clr_regs_o[g]),
            .addr_flat (ch_addr_o[g*CH*REG_W +: CH*REG_W]),
            .cnt_flat  (ch_count_o[g*CH*REG_W +: CH*REG_W])
        );
    end

    always_comb begin
        io_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            io_rdata = io_rdata | grp_data[g];
        end
    end

    assign io_rd_hit = |grp_hit;

    assert_single_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_hit));

    assert_hit_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd_hit |-> io_rd);

endmodule

// File: tb/sim_dma_cmd_front.sv
module sim_dma_cmd_front;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [1:0]   eng_start = '0;
    logic [7:0]   io_rdata;
    logic         io_rd_hit;
    logic [7:0]   mask_o;
    logic [1:0]   bptr_o;
    logic [1:0]   idle_o;
    logic [1:0]   clr_regs_o;
    logic [127:0] ch_addr_o;
    logic [127:0] ch_count_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [7:0] rb;
    logic       rh;

    always #5 clk = ~clk;

    dma_cmd_front u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .eng_start  (eng_start),
        .io_rdata   (io_rdata),
        .io_rd_hit  (io_rd_hit),
        .mask_o     (mask_o),
        .bptr_o     (bptr_o),
        .idle_o     (idle_o),
        .clr_regs_o (clr_regs_o),
        .ch_addr_o  (ch_addr_o),
        .ch_count_o (ch_count_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        rb = io_rdata; rh = io_rd_hit;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 mask", 32'(mask_o), 32'hFF);
        chk("R1 bptr", 32'(bptr_o), 0);
        chk("R1 idle", 32'(idle_o), 3);
        chk("R1 clr", 32'(clr_regs_o), 0);
        chk("R1 regs", 32'(|{ch_addr_o, ch_count_o}), 0);
    endtask

    task automatic t_map;
        for (int n = 0; n < 4; n++) begin
            wr(16'(2*n), 8'(8'h10+n)); wr(16'(2*n), 8'(8'hA0+n));
            wr(16'(2*n+1), 8'(8'h20+n)); wr(16'(2*n+1), 8'(8'hB0+n));
            wr(16'(16'h00C0+4*n), 8'(8'h30+n)); wr(16'(16'h00C0+4*n), 8'(8'hC0+n));
            wr(16'(16'h00C2+4*n), 8'(8'h40+n)); wr(16'(16'h00C2+4*n), 8'(8'hD0+n));
        end
        for (int n = 0; n < 4; n++) begin
            chk("R2 g0 addr", 32'(ch_addr_o[16*n +: 16]), 32'({8'(8'hA0+n), 8'(8'h10+n)}));
            chk("R2 g0 cnt", 32'(ch_count_o[16*n +: 16]), 32'({8'(8'hB0+n), 8'(8'h20+n)}));
            chk("R2 g1 addr", 32'(ch_addr_o[16*(n+4) +: 16]), 32'({8'(8'hC0+n), 8'(8'h30+n)}));
            chk("R2 g1 cnt", 32'(ch_count_o[16*(n+4) +: 16]), 32'({8'(8'hD0+n), 8'(8'h40+n)}));
        end
    endtask

    task automatic t_interleave;
        wr(16'h0004, 8'hAA);
        chk("R3 g0 bptr high", 32'(bptr_o[0]), 1);
        wr(16'h000C, 8'h5A);
        chk("R4 g0 bptr cleared", 32'(bptr_o[0]), 0);
        wr(16'h0004, 8'h78); wr(16'h0004, 8'h56);
        chk("R4 g0 sequence", 32'(ch_addr_o[32 +: 16]), 32'h5678);
        wr(16'h00C6, 8'h11);
        wr(16'h00D8, 8'h00);
        chk("R4 g1 bptr cleared", 32'(bptr_o[1]), 0);
        wr(16'h00C6, 8'hEF); wr(16'h00C6, 8'hCD);
        chk("R4 g1 sequence", 32'(ch_count_o[16*5 +: 16]), 32'hCDEF);
        rd(16'h0004);
        chk("R3 read low hit", 32'(rh), 1);
        chk("R3 read low", 32'(rb), 32'h78);
        rd(16'h0005);
        chk("R3 read count high", 32'(rb), 32'hB2);
        chk("R3 bptr after reads", 32'(bptr_o[0]), 0);
    endtask

    task automatic t_masks;
        wr(16'h000E, 8'h00);
        chk("R6 g0 mask clear", 32'(mask_o), 32'hF0);
        wr(16'h00DC, 8'hFF);
        chk("R6 g1 mask clear", 32'(mask_o), 32'h00);
        wr(16'h0000, 8'h01);
        wr(16'h00DA, 8'h33);
        chk("R5 g1 mask set", 32'(mask_o), 32'hF0);
        chk("R5 g1 clr pulse", 32'(clr_regs_o), 2);
        chk("R7 g0 bptr kept", 32'(bptr_o[0]), 1);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(clr_regs_o), 0);
        wr(16'h00D8, 8'h00);
        chk("R7 g0 bptr after g1 clear", 32'(bptr_o[0]), 1);
        wr(16'h000D, 8'hC3);
        chk("R5 g0 bptr", 32'(bptr_o[0]), 0);
        chk("R5 g0 mask", 32'(mask_o), 32'hFF);
        chk("R5 g0 pulse", 32'(clr_regs_o), 1);
    endtask

    task automatic t_idle;
        @(negedge clk); eng_start = 2'b01;
        @(negedge clk); eng_start = 2'b00;
        chk("R9 g0 busy", 32'(idle_o), 2);
        @(negedge clk); eng_start = 2'b10;
        io_addr = 16'h00DA; io_wr = 1'b1;
        @(negedge clk); eng_start = 2'b00; io_wr = 1'b0;
        chk("R9 mclr wins", 32'(idle_o), 2);
        wr(16'h000D, 8'h00);
        chk("R9 g0 idle again", 32'(idle_o), 3);
    endtask

    task automatic t_cmd_read;
        wr(16'h00C0, 8'h01);
        rd(16'h00DA);
        chk("R8 cmd read no hit", 32'(rh), 0);
        rd(16'h000E);
        chk("R8 cmd read no hit g0", 32'(rh), 0);
        chk("R8 bptr unchanged", 32'(bptr_o), 2);
        chk("R8 mask unchanged", 32'(mask_o), 32'hFF);
    endtask

    task automatic t_unmapped;
        logic [127:0] a0, c0;
        a0 = ch_addr_o; c0 = ch_count_o;
        wr(16'h0008, 8'h99);
        wr(16'h00C1, 8'h99);
        wr(16'h100C, 8'h99);
        wr(16'h10DC, 8'h99);
        rd(16'h1004);
        chk("R10 no read hit", 32'(rh), 0);
        chk("R10 bptr", 32'(bptr_o), 2);
        chk("R10 mask", 32'(mask_o), 32'hFF);
        chk("R10 regs", 32'({ch_addr_o, ch_count_o} == {a0, c0}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_interleave();
        t_masks();
        t_idle();
        t_cmd_read();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule